// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block turns a table of region descriptors in system memory into a sequence of memory transfer requests for a device data buffer. Software places the table somewhere in memory. A start pulse then gives the walker the table base, the total number of bytes the device wants moved, and the direction of the move. The walker fetches one 8-byte descriptor at a time over a read request/response path. Each descriptor names a physical region and its size. The walker then issues one read or write request per chunk toward the memory port and tracks how many bytes are left in the region and in the request.

The table ends in one of two ways: the walker exhausts the region of a descriptor flagged as final, or the descriptor pointer runs one full 4 KiB page past the base. The second case is a safety limit against tables that never terminate. If the device's byte count is met first, the walker pulses done. If the table runs out first, it pulses a short-table flag, and it also raises an error flag when the page limit was the cause.

Top module: `prd_walker`

## Requirements
- R1: A start pulse taken while idle captures the table base, the byte count and the direction. It clears any region state left from earlier work, so the first memory action of every operation is a descriptor fetch at the base address.
- R2: The low word of a descriptor (`desc_data_i[31:0]`) is the region address. The high word (`desc_data_i[63:32]`) is the size word. The region byte count is size bits 15:1 times two. Size bit 0 and size bits 30:16 are ignored.
- R3: A size word whose bits 15:1 are all zero describes a region of 65536 bytes.
- R4: Size bit 31 set marks the final descriptor. Once that region is used up, no further descriptor is fetched.
- R5: The k-th fetch of an operation (k counted from 0) reads address base + 8k. A fetch happens only when the current region has no bytes left.
- R6: Each chunk request carries a length equal to the smaller of the bytes still needed and the bytes left in the region. Its address is the region address advanced by all earlier chunks from that region.
- R7: `mem_we_o` equals the direction captured at start (1 = device to memory) for every chunk of the operation.
- R8: `done_o` pulses for one cycle once the chunk lengths sum to the byte count. A byte count of zero gives done with no fetch and no chunk. Done takes priority when the count is met exactly as the final region ends.
- R9: When the final region is used up before the count is met, `short_o` pulses for one cycle with `err_o` low.
- R10: When 512 descriptors (4096 bytes) have been fetched, none of them final, and the count is still unmet, `short_o` and `err_o` pulse together. No operation makes more than 512 fetches.
- R11: A request (fetch or chunk) held while `mem_ready_i` is low keeps its valid and its address and length unchanged. The request is accepted in a cycle where ready is high.
- R12: `desc_valid_i` is consumed only while a fetch is outstanding, exactly once per fetch. Responses at other times have no effect on the requests issued.
- R13: After reset no request or status pulse is active. At most one request type is active at a time, and `done_o` and `short_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (taken when idle) |
| base_i | input | 32 | Descriptor table base address |
| need_i | input | NEED_W | Bytes the device wants moved |
| dir_wr_i | input | 1 | 1 = device to memory, 0 = memory to device |
| desc_req_o | output | 1 | Descriptor fetch request |
| desc_addr_o | output | 32 | Descriptor fetch address |
| desc_valid_i | input | 1 | Descriptor response valid |
| desc_data_i | input | 64 | Descriptor response, little-endian word pair |
| mem_req_o | output | 1 | Chunk transfer request |
| mem_we_o | output | 1 | Chunk is a memory write |
| mem_addr_o | output | 32 | Chunk physical address |
| mem_len_o | output | 17 | Chunk length in bytes |
| mem_ready_i | input | 1 | Memory port accepts the current request |
| done_o | output | 1 | Byte count satisfied (pulse) |
| short_o | output | 1 | Table ended before the count was met (pulse) |
| err_o | output | 1 | Table ended by the page limit (pulse) |

## Verification
Random tables of one to six descriptors carry junk in the ignored size bits, odd size bits, random addresses and random byte counts. Against a bench model of the walk, they separate correct chunk splitting from off-by-one region accounting and wrong field decoding. Random ready stalls and stray response pulses show whether the handshake holds requests and consumes only real responses. Directed tables isolate the zero-count region, an exact fit at the final region (done against short), a final flag followed by more entries, a restart over leftover region bytes, and a 512-entry table with no final flag that can only end through the page limit.

// File: rtl/prd_walk_pkg.sv
package prd_walk_pkg;
  localparam int ADDR_W     = 32;
  localparam int CNT_W      = 16;
  localparam int LEN_W      = CNT_W + 1;
  localparam int DESC_W     = 64;
  localparam int DESC_BYTES = DESC_W / 8;
  localparam int LAST_BIT   = 31;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FETCH,
    ST_WAIT,
    ST_XFER
  } walk_st_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len;
    logic              last;
  } region_t;
endpackage

// File: rtl/prd_decode.sv
module prd_decode
  import prd_walk_pkg::*;
(
  input  logic [DESC_W-1:0] raw_i,
  output region_t           reg_o
);
  logic [CNT_W-1:0] cnt;
  logic             unused_bits;

  assign unused_bits = ^{raw_i[32+LAST_BIT-1:32+CNT_W], raw_i[32]};

  always_comb begin
    cnt        = {raw_i[32+CNT_W-1:33], 1'b0};
    reg_o.addr = raw_i[ADDR_W-1:0];
    reg_o.len  = (cnt == '0) ? (LEN_W'(1) << CNT_W) : LEN_W'(cnt);
    reg_o.last = raw_i[32+LAST_BIT];
  end
endmodule

// File: rtl/prd_ptr_guard.sv
module prd_ptr_guard
  import prd_walk_pkg::*;
#(
  parameter int GUARD_BYTES = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              limit_o
);
  localparam int OFF_W = $clog2(GUARD_BYTES + 1);

  logic [ADDR_W-1:0] base_q;
  logic [OFF_W-1:0]  off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      off_q  <= '0;
    end else if (load_i) begin
      base_q <= base_i;
      off_q  <= '0;
    end else if (step_i && !limit_o) begin
      off_q <= off_q + OFF_W'(DESC_BYTES);
    end
  end

  assign ptr_o   = base_q + ADDR_W'(off_q);
  assign limit_o = (off_q >= OFF_W'(GUARD_BYTES));
endmodule

// File: rtl/prd_chunk_sel.sv
module prd_chunk_sel
  import prd_walk_pkg::*;
#(
  parameter int NEED_W = 20
) (
  input  logic [NEED_W-1:0] rem_i,
  input  logic [LEN_W-1:0]  avail_i,
  output logic [LEN_W-1:0]  chunk_o
);
  localparam int CMP_W = (NEED_W > LEN_W) ? NEED_W : LEN_W;

  logic [CMP_W-1:0] rem_x;
  logic [CMP_W-1:0] av_x;

  assign rem_x   = CMP_W'(rem_i);
  assign av_x    = CMP_W'(avail_i);
  assign chunk_o = (rem_x < av_x) ? LEN_W'(rem_x) : avail_i;
endmodule

// File: rtl/prd_walker.sv
module prd_walker
  import prd_walk_pkg::*;
#(
  parameter int NEED_W      = 20,
  parameter int GUARD_BYTES = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [NEED_W-1:0] need_i,
  input  logic              dir_wr_i,
  output logic              desc_req_o,
  output logic [ADDR_W-1:0] desc_addr_o,
  input  logic              desc_valid_i,
  input  logic [DESC_W-1:0] desc_data_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [LEN_W-1:0]  mem_len_o,
  input  logic              mem_ready_i,
  output logic              done_o,
  output logic              short_o,
  output logic              err_o
);
  walk_st_e          st_q;
  logic [NEED_W-1:0] rem_q;
  logic [ADDR_W-1:0] cur_addr_q;
  logic [LEN_W-1:0]  cur_len_q;
  logic              last_q;
  logic              we_q;
  logic              done_q, short_q, err_q;

  region_t           dec;
  logic [LEN_W-1:0]  chunk;
  logic              at_limit;
  logic              load;
  logic              step;

  assign load = (st_q == ST_IDLE) && start_i;
  assign step = (st_q == ST_FETCH) && mem_ready_i;

  prd_decode u_dec (
    .raw_i (desc_data_i),
    .reg_o (dec)
  );

  prd_ptr_guard #(.GUARD_BYTES(GUARD_BYTES)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .base_i  (base_i),
    .step_i  (step),
    .ptr_o   (desc_addr_o),
    .limit_o (at_limit)
  );

  prd_chunk_sel #(.NEED_W(NEED_W)) u_chunk (
    .rem_i   (rem_q),
    .avail_i (cur_len_q),
    .chunk_o (chunk)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      rem_q      <= '0;
      cur_addr_q <= '0;
      cur_len_q  <= '0;
      last_q     <= 1'b0;
      we_q       <= 1'b0;
      done_q     <= 1'b0;
      short_q    <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      short_q <= 1'b0;
      err_q   <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          rem_q      <= need_i;
          we_q       <= dir_wr_i;
          cur_addr_q <= '0;
          cur_len_q  <= '0;
          last_q     <= 1'b0;
          st_q       <= ST_CHECK;
        end
        ST_CHECK: begin
          // count satisfied wins over table end
          if (rem_q == '0) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else if (cur_len_q != '0) begin
            st_q <= ST_XFER;
          end else if (last_q || at_limit) begin
            short_q <= 1'b1;
            err_q   <= !last_q;
            st_q    <= ST_IDLE;
          end else begin
            st_q <= ST_FETCH;
          end
        end
        ST_FETCH: if (mem_ready_i) st_q <= ST_WAIT;
        ST_WAIT: if (desc_valid_i) begin
          cur_addr_q <= dec.addr;
          cur_len_q  <= dec.len;
          last_q     <= dec.last;
          st_q       <= ST_CHECK;
        end
        ST_XFER: if (mem_ready_i) begin
          cur_addr_q <= cur_addr_q + ADDR_W'(chunk);
          cur_len_q  <= cur_len_q - chunk;
          rem_q      <= rem_q - NEED_W'(chunk);
          st_q       <= ST_CHECK;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign desc_req_o = (st_q == ST_FETCH);
  assign mem_req_o  = (st_q == ST_XFER);
  assign mem_we_o   = we_q;
  assign mem_addr_o = cur_addr_q;
  assign mem_len_o  = chunk;
  assign done_o     = done_q;
  assign short_o    = short_q;
  assign err_o      = err_q;
endmodule

// File: rtl/prd_walker_chk.sv
module prd_walker_chk
  import prd_walk_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              desc_req_o,
  input logic [ADDR_W-1:0] desc_addr_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [LEN_W-1:0]  mem_len_o,
  input logic              mem_ready_i,
  input logic              done_o,
  input logic              short_o,
  input logic              err_o
);
  AST_DESC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_req_o && !mem_ready_i |=> desc_req_o && $stable(desc_addr_o)); // R11
  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_len_o)); // R11
  AST_LEN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_len_o != '0) && (mem_len_o <= (LEN_W'(1) << CNT_W))); // R6
  AST_ONE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({desc_req_o, mem_req_o})); // R13
  AST_END_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && short_o)); // R13
  AST_ERR_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> short_o); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_SHORT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_o |=> !short_o); // R9
endmodule

bind prd_walker prd_walker_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .desc_req_o  (desc_req_o),
  .desc_addr_o (desc_addr_o),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_len_o   (mem_len_o),
  .mem_ready_i (mem_ready_i),
  .done_o      (done_o),
  .short_o     (short_o),
  .err_o       (err_o)
);

// File: tb/tb_prd_walker.sv
module tb_prd_walker;
  import prd_walk_pkg::*;

  localparam int NEED_W = 20;
  localparam int GUARD  = 4096;
  localparam int NTBL   = GUARD / 8;
  localparam int LOGN   = 600;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [ADDR_W-1:0] base_i = '0;
  logic [NEED_W-1:0] need_i = '0;
  logic              dir_wr_i = 1'b0;
  logic              desc_req_o;
  logic [ADDR_W-1:0] desc_addr_o;
  logic              desc_valid_i = 1'b0;
  logic [DESC_W-1:0] desc_data_i = '0;
  logic              mem_req_o;
  logic              mem_we_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [LEN_W-1:0]  mem_len_o;
  logic              mem_ready_i = 1'b0;
  logic              done_o, short_o, err_o;

  prd_walker #(.NEED_W(NEED_W), .GUARD_BYTES(GUARD)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .base_i(base_i),
    .need_i(need_i), .dir_wr_i(dir_wr_i), .desc_req_o(desc_req_o),
    .desc_addr_o(desc_addr_o), .desc_valid_i(desc_valid_i),
    .desc_data_i(desc_data_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_len_o(mem_len_o), .mem_ready_i(mem_ready_i),
    .done_o(done_o), .short_o(short_o), .err_o(err_o)
  );

  always #5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  logic [63:0] tbl [NTBL];
  logic [31:0] exp_f [LOGN];
  logic [31:0] exp_ca [LOGN];
  int          exp_cl [LOGN];
  int          nf_exp, nc_exp, exp_out;
  logic [31:0] obs_f [LOGN];
  logic [31:0] obs_ca [LOGN];
  int          obs_cl [LOGN];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_fail++;
      $display("FAIL R13 watchdog: actual %0d cycles expected under 190000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic clear_tbl();
    for (int i = 0; i < NTBL; i++) tbl[i] = '0;
  endtask

  task automatic put(input int i, input logic [31:0] a, input logic [31:0] sz);
    tbl[i] = {sz, a};
  endtask

  // walk model built from the requirements
  task automatic model(input logic [31:0] base, input int need);
    int off = 0;
    int rem = need;
    int clen = 0;
    bit last = 0;
    logic [31:0] caddr = '0;
    logic [63:0] e;
    nf_exp = 0;
    nc_exp = 0;
    forever begin
      if (rem == 0) begin exp_out = 0; break; end
      if (clen == 0) begin
        if (last) begin exp_out = 1; break; end
        if (off >= GUARD) begin exp_out = 2; break; end
        exp_f[nf_exp] = base + 32'(off);
        nf_exp++;
        e = tbl[off/8];
        off += 8;
        caddr = e[31:0];
        clen = int'(e[47:33]) * 2;
        if (clen == 0) clen = 65536;
        last = e[63];
      end else begin
        int ch;
        ch = (rem < clen) ? rem : clen;
        exp_ca[nc_exp] = caddr;
        exp_cl[nc_exp] = ch;
        nc_exp++;
        caddr += 32'(ch);
        clen -= ch;
        rem -= ch;
      end
    end
  endtask

  task automatic run_op(input logic [31:0] base, input int need, input bit dir,
                        input string tag);
    int nf = 0, nc = 0, we_bad = 0, hold_bad = 0, got = -1, both = 0;
    bit pend = 0, p_d = 0, p_m = 0;
    int pd = 0;
    logic [63:0] pdata = '0;
    logic [31:0] p_da = '0, p_ma = '0;
    logic [LEN_W-1:0] p_ml = '0;
    bit f_ok, c_ok;
    string otag;
    model(base, need);
    @(negedge clk);
    start_i = 1'b1; base_i = base; need_i = NEED_W'(need); dir_wr_i = dir;
    @(negedge clk);
    start_i = 1'b0;
    for (int c = 0; c < 20000; c++) begin
      if (p_d && !(desc_req_o && desc_addr_o == p_da)) hold_bad++;
      if (p_m && !(mem_req_o && mem_addr_o == p_ma && mem_len_o == p_ml)) hold_bad++;
      if (done_o || short_o) begin
        got = done_o ? 0 : (err_o ? 2 : 1);
        both = (done_o && short_o) ? 1 : 0;
        break;
      end
      desc_valid_i = 1'b0;
      if (pend) begin
        if (pd == 0) begin
          desc_valid_i = 1'b1; desc_data_i = pdata; pend = 0;
        end else pd--;
      end else if ($urandom % 8 == 0) begin
        desc_valid_i = 1'b1;  // stray response, R12
        desc_data_i = {$urandom, $urandom};
      end
      mem_ready_i = ($urandom % 4) != 0;
      if (desc_req_o && mem_ready_i) begin
        int idx;
        if (nf < LOGN) obs_f[nf] = desc_addr_o;
        nf++;
        pend = 1;
        pd = int'($urandom % 3);
        idx = int'((desc_addr_o - base) >> 3);
        pdata = (idx >= 0 && idx < NTBL) ? tbl[idx] : '0;
      end
      if (mem_req_o && mem_ready_i) begin
        if (nc < LOGN) begin obs_ca[nc] = mem_addr_o; obs_cl[nc] = int'(mem_len_o); end
        nc++;
        if (mem_we_o !== dir) we_bad++;
      end
      p_d = desc_req_o && !mem_ready_i; p_da = desc_addr_o;
      p_m = mem_req_o && !mem_ready_i; p_ma = mem_addr_o; p_ml = mem_len_o;
      @(negedge clk);
    end
    desc_valid_i = 1'b0;
    otag = (exp_out == 0) ? "R8" : (exp_out == 1) ? "R9" : "R10";
    check(got == exp_out, {tag, "/", otag}, "outcome", got, exp_out);
    f_ok = (nf == nf_exp);
    for (int i = 0; i < nf_exp && i < nf && i < LOGN; i++)
      if (obs_f[i] !== exp_f[i]) f_ok = 0;
    check(f_ok, {tag, "/R5"}, "fetch count/addresses", nf, nf_exp);
    c_ok = (nc == nc_exp);
    for (int i = 0; i < nc_exp && i < nc && i < LOGN; i++)
      if (obs_ca[i] !== exp_ca[i] || obs_cl[i] != exp_cl[i]) c_ok = 0;
    check(c_ok, {tag, "/R6"}, "chunk count/addr/len", nc, nc_exp);
    check(we_bad == 0, {tag, "/R7"}, "direction mismatches", we_bad, 0);
    check(hold_bad == 0, {tag, "/R11"}, "held request changed", hold_bad, 0);
    check(both == 0, {tag, "/R13"}, "done with short", both, 0);
    @(negedge clk);
    check(!done_o && !short_o && !err_o, {tag, "/R8"}, "pulse after end",
          longint'({done_o, short_o, err_o}), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    clear_tbl();
    repeat (3) @(negedge clk);
    // R13 reset state
    check(!desc_req_o && !mem_req_o && !done_o && !short_o && !err_o, "R13",
          "outputs in reset", longint'({desc_req_o, mem_req_o, done_o, short_o, err_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!desc_req_o && !mem_req_o && !done_o && !short_o, "R13", "idle after reset",
          longint'({desc_req_o, mem_req_o, done_o, short_o}), 0);

    // R8 zero byte count
    clear_tbl(); put(0, 32'h1000, 32'h8000_0010);
    run_op(32'h0000_4000, 0, 1'b0, "R8");

    // R3 zero encoded count means 65536 (bit 0 set, still zero)
    clear_tbl(); put(0, 32'h0010_0000, 32'h8000_0001);
    run_op(32'h0000_8000, 70000, 1'b1, "R3");

    // R2 junk in ignored size bits: count 100
    clear_tbl(); put(0, 32'h0002_0000, 32'h7fff_0065); put(1, 32'h0003_0000, 32'h8000_0040);
    run_op(32'h0000_9000, 150, 1'b0, "R2");

    // R8 exact fit on the final region: done, not short
    clear_tbl(); put(0, 32'h0004_0000, 32'h0000_0064); put(1, 32'h0005_0000, 32'h8000_00c8);
    run_op(32'h0000_a000, 300, 1'b1, "R8");

    // R4 entries after the final one are not fetched
    clear_tbl(); put(0, 32'h0006_0000, 32'h8000_0032); put(1, 32'h0007_0000, 32'h0000_0032);
    run_op(32'h0000_b000, 500, 1'b0, "R4");

    // R1 restart over leftover region bytes
    clear_tbl(); put(0, 32'h0008_0000, 32'h8000_03e8);
    run_op(32'h0000_c000, 100, 1'b0, "R1");
    run_op(32'h0000_c000, 50, 1'b1, "R1");

    // R10 page limit: 512 non-final entries
    for (int i = 0; i < NTBL; i++) put(i, 32'h0100_0000 + 32'(i * 16), 32'h0000_0002);
    run_op(32'h0001_0000, 20000, 1'b1, "R10");

    // R12 with random stray responses throughout; random tables
    for (int t = 0; t < 40; t++) begin
      int nd;
      int need;
      logic [31:0] base;
      clear_tbl();
      nd = 1 + int'($urandom % 6);
      for (int i = 0; i < nd; i++) begin
        logic [15:0] sz;
        logic [14:0] junk;
        sz = ($urandom % 10 == 0) ? 16'($urandom % 2) : 16'($urandom % 1500);
        junk = 15'($urandom);
        put(i, $urandom, {(i == nd - 1) ? 1'b1 : 1'b0, junk, sz});
      end
      need = ($urandom % 5 == 0) ? int'($urandom % 70000) : int'($urandom % 3000);
      base = {$urandom} & 32'hffff_fff8;
      run_op(base, need, 1'($urandom), "R12");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule